// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a countdown timer that raises an interrupt request carrying a programmed 8-bit vector. Software reaches it through a small register port with four selectable items: the initial count, the divide configuration, the timer vector entry (vector, mask and periodic-mode bits) and the current count, which is read only. A prescaler turns the system clock into timer ticks at a power-of-two rate chosen by the divide configuration. The counter then counts down once (one-shot) or over and over (periodic).

When the count expires and the entry is not masked, the block drives a one-clock request with the vector beside it. An interrupt controller downstream takes this request and applies its own priority logic. Bus address decoding is done outside the block, which only sees a 2-bit register select.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, the initial count, divide configuration and current count read 0, the vector entry reads 0x00010000 (masked), and no request is driven.
- R2: The divide register keeps only bits 3, 1 and 0 and reads all other bits as 0. The code v = {bit3, bit1, bit0} selects a divide of 2^((v+1) mod 8): code 7 divides by 1, code 0 by 2, code 6 by 128.
- R3: The vector entry keeps bits 7:0 (vector), bit 16 (mask) and bit 17 (periodic) and reads all other bits as 0.
- R4: With divide D, the current count k clocks after an initial-count write equals initial minus floor(k/D). In one-shot mode it holds at 0 once it gets there, and it never exceeds the initial count.
- R5: In one-shot mode, exactly one request is raised, (initial+1)·D clocks after the initial-count write.
- R6: In periodic mode, a request is raised every (initial+1)·D clocks, and the count wraps from 0 back to initial.
- R7: In periodic mode with an initial count of 0, no request is ever raised.
- R8: Writing the initial count restarts both the prescaler and the count from the moment of the write.
- R9: A request is high for exactly one clock, with the entry's vector on irq_vector in that clock. No request is issued while the mask bit is set.
- R10: Writes to the current-count select (3) change no state. Select codes: 0 = initial count, 1 = divide, 2 = vector entry, 3 = current count. A read returns on rd_data one clock after reg_sel is applied.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select (0 init, 1 divide, 2 vector entry, 3 current count) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data of the selected register |
| irq_req | output | 1 | One-clock expiry request |
| irq_vector | output | 8 | Vector that goes with irq_req |

## Verification
On every cycle, the assertions check the following:
- the count never rises above the initial value;
- a one-shot expiry disarms the counter;
- a periodic timer with a zero initial count stays silent;
- prescaler ticks are never back to back when the divide is above one;
- the request never lasts two clocks.

Only the bench's scenarios can show the following:
- the exact expiry cycle for each divide code;
- the period of repeated expiries;
- the sampled current count partway through a run;
- the restart on a new initial-count write;
- that masked, read-only and unused register bits have no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W    = 32;
  localparam int VEC_W     = 8;
  localparam int SHIFT_W   = 3;
  localparam int MASK_POS  = 16;
  localparam int PER_POS   = 17;

  typedef enum logic [1:0] {
    SEL_INIT  = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_COUNT = 2'd3
  } tmr_sel_e;

  localparam logic [DATA_W-1:0] ENTRY_RESET = DATA_W'(1) << MASK_POS;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  assign low_mask = ~({PRE_W{1'b1}} << shift);
  assign tick     = !clear && ((pre_q & low_mask) == low_mask);

  always_ff @(posedge clk) begin
    if (rst || clear) pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end

  // R2: above divide-by-1, ticks are separated by at least one idle clock
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && shift != '0) |=> (!tick || shift == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire
);
  logic armed_q;
  logic at_zero;

  assign at_zero = (cur_q == '0);
  assign expire  = tick && !load && at_zero &&
                   (periodic ? (init_q != '0) : armed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q  <= '0;
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      init_q  <= load_val;
      cur_q   <= load_val;
      armed_q <= 1'b1;
    end else if (tick) begin
      if (!at_zero)      cur_q <= cur_q - CNT_W'(1);
      else if (periodic) cur_q <= init_q;
      if (expire && !periodic) armed_q <= 1'b0;
    end
  end

  // R4: the running count stays within the programmed range
  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    cur_q <= init_q);
  // R5: a one-shot expiry leaves the counter disarmed
  assert_oneshot_once_R5: assert property (@(posedge clk) disable iff (rst)
    (expire && !periodic) |=> !armed_q);
  // R7: periodic with zero initial count never expires
  assert_periodic_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (periodic && init_q == '0) |-> !expire);
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [SHIFT_W-1:0] div_code_q;
  logic [VEC_W-1:0]   vec_q;
  logic               mask_q;
  logic               per_q;
  logic [SHIFT_W-1:0] shift;
  logic               load;
  logic               tick;
  logic               expire;
  logic [DATA_W-1:0]  init_q;
  logic [DATA_W-1:0]  cur_q;
  logic [DATA_W-1:0]  div_view;
  logic [DATA_W-1:0]  entry_view;

  assign load  = wr_en && (tmr_sel_e'(reg_sel) == SEL_INIT);
  assign shift = div_code_q + SHIFT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_code_q <= '0;
      vec_q      <= '0;
      mask_q     <= 1'b1;
      per_q      <= 1'b0;
    end else if (wr_en) begin
      case (tmr_sel_e'(reg_sel))
        SEL_DIV:   div_code_q <= {wr_data[3], wr_data[1], wr_data[0]};
        SEL_ENTRY: begin
          vec_q  <= wr_data[VEC_W-1:0];
          mask_q <= wr_data[MASK_POS];
          per_q  <= wr_data[PER_POS];
        end
        default: ;
      endcase
    end
  end

  tmr_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst(rst), .clear(load), .shift(shift), .tick(tick)
  );

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data), .tick(tick),
    .periodic(per_q), .init_q(init_q), .cur_q(cur_q), .expire(expire)
  );

  always_comb begin
    div_view    = '0;
    div_view[3] = div_code_q[2];
    div_view[1] = div_code_q[1];
    div_view[0] = div_code_q[0];
    entry_view  = '0;
    entry_view[VEC_W-1:0] = vec_q;
    entry_view[MASK_POS]  = mask_q;
    entry_view[PER_POS]   = per_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      irq_req    <= 1'b0;
      irq_vector <= '0;
    end else begin
      case (tmr_sel_e'(reg_sel))
        SEL_INIT:  rd_data <= init_q;
        SEL_DIV:   rd_data <= div_view;
        SEL_ENTRY: rd_data <= entry_view;
        default:   rd_data <= cur_q;
      endcase
      irq_req    <= expire && !mask_q;
      irq_vector <= vec_q;
    end
  end

  // R9: every request lasts exactly one clock
  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);
endmodule

// File: tb/irq_countdown_timer_tb.sv
`timescale 1ns/1ps
module irq_countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  reg_sel;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  irq_countdown_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req),
    .irq_vector(irq_vector)
  );

  // {periodic, divide register bits 3:0, initial count}
  localparam int NV = 6;
  localparam logic [36:0] VTBL [NV] = '{
    {1'b0, 4'hB, 32'd5},
    {1'b0, 4'h0, 32'd3},
    {1'b1, 4'h1, 32'd2},
    {1'b0, 4'h8, 32'd1},
    {1'b0, 4'hA, 32'd0},
    {1'b1, 4'h3, 32'd2}
  };

  function automatic int div_of(input logic [3:0] raw);
    logic [2:0] v;
    v = {raw[3], raw[1], raw[0]};
    return 1 << int'(3'(v + 3'd1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_fire(input int limit, output int n, output logic [7:0] vec);
    n = 0;
    vec = 8'h00;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (irq_req) begin
        vec = irq_vector;
        return;
      end
    end
    n = -1;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    logic [7:0] vec;
    rst = 1'b1; wr_en = 1'b0; reg_sel = 2'd0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq idle", {31'd0, irq_req}, 32'd0);
    rd(2'd0, d); chk("R1 init", d, 32'd0);
    rd(2'd1, d); chk("R1 divide", d, 32'd0);
    rd(2'd2, d); chk("R1 entry", d, 32'h0001_0000);
    rd(2'd3, d); chk("R1 count", d, 32'd0);

    // R2 / R3: stored bits only
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 divide bits", d, 32'h0000_000B);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); chk("R3 entry bits", d, 32'h0003_00FF);

    // Table: R5 one-shot timing, R6 periodic timing, R2 divide codes
    for (int i = 0; i < NV; i++) begin
      logic        per;
      logic [3:0]  draw;
      logic [31:0] ini;
      int          expn;
      {per, draw, ini} = VTBL[i];
      expn = (int'(ini) + 1) * div_of(draw);
      wr(2'd2, {14'd0, per, 1'b1, 8'd0, 8'(8'h20 + i)});
      wr(2'd1, {28'd0, draw});
      wr(2'd2, {14'd0, per, 1'b0, 8'd0, 8'(8'h20 + i)});
      wr(2'd0, ini);
      // the entry write above lands before the load; count from the load write
      wait_fire(3 * expn + 8, n, vec);
      chk(per ? "R6 first period" : "R5 expiry cycle", n, expn);
      chk("R9 vector", {24'd0, vec}, {24'd0, 8'(8'h20 + i)});
      if (per) begin
        wait_fire(3 * expn + 8, n, vec);
        chk("R6 repeat period", n, expn);
        wr(2'd2, {14'd0, 1'b1, 1'b1, 16'd0});
      end else begin
        wait_fire(2 * expn + 8, n, vec);
        chk("R5 single expiry", n, -1);
      end
    end

    // R4: mid-run count with divide 128 (code 6)
    wr(2'd2, 32'h0001_0000);
    wr(2'd1, 32'h0000_000A);
    wr(2'd0, 32'd1000);
    reg_sel = 2'd3;
    repeat (299) @(posedge clk);
    @(negedge clk);
    chk("R4 count after 298 clocks", rd_data, 32'd1000 - 32'(298 / 128));

    // R4 hold at zero, R9 mask
    wr(2'd1, 32'h0000_000B);
    wr(2'd2, 32'h0001_0033);
    wr(2'd0, 32'd3);
    wait_fire(30, n, vec);
    chk("R9 masked no request", n, -1);
    rd(2'd3, d); chk("R4 one-shot holds zero", d, 32'd0);

    // R10: writes to the count select are ignored
    wr(2'd3, 32'd55);
    rd(2'd3, d); chk("R10 count unchanged", d, 32'd0);
    rd(2'd0, d); chk("R10 init unchanged", d, 32'd3);

    // R7: periodic with zero initial count
    wr(2'd2, 32'h0002_0044);
    wr(2'd0, 32'd0);
    wait_fire(40, n, vec);
    chk("R7 periodic zero silent", n, -1);

    // R8: reload restarts the count
    wr(2'd2, 32'h0000_0055);
    wr(2'd0, 32'd10);
    repeat (4) @(posedge clk);
    wr(2'd0, 32'd4);
    wait_fire(40, n, vec);
    chk("R8 restart expiry", n, 5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule